// File: doc/BRIEF.md
# I2C Master Bit Engine with Arbitration

This block is the bit-level engine of a single I2C bus master. It produces SCL from a programmable timer period and shifts a short message onto SDA. The message is made of one to `MAX_BYTES` bytes, and byte 0 is normally the address. The engine frames the message with START and STOP conditions and leaves SDA released in every acknowledge slot. Both lines are open-drain. For each line the engine gives a drive-low enable and reads back the resolved level.

A passive bus monitor watches the resolved lines for START and STOP conditions from any master and reports whether the bus is idle. A new transfer is taken only while the bus is idle. While a data bit is a released '1', the engine compares what it sent with what it reads on SDA. If another master holds the line low, the engine stops driving both lines at once and raises an arbitration-lost flag. That flag stays set until a later request is accepted.

Timing is counted in prescaled ticks. One tick is 2·(1+TPR) system clocks. Each SCL slot is 10 ticks: SCL is low for ticks 0–5 and released for ticks 6–9. SDA is updated at tick 0, and SDA is sampled at the tick-7/8 boundary, which is the middle of the high phase.

Top module: `i2cbe_top`

## Requirements
- R1: With the timer value latched when a request is accepted, SCL stays low for 12·(1+TPR) clocks and then released for 8·(1+TPR) clocks in every bit slot. A full rise-to-rise period is therefore 20·(1+TPR) clocks. A TPR of 0 is legal.
- R2: A request is accepted only when the engine is idle, `bus_idle` is 1 and `byte_cnt` lies between 1 and `MAX_BYTES`. `busy` is then 1 from the next cycle. Any other request is ignored: `busy` stays 0 and neither line is driven.
- R3: A transfer opens with both lines released for 5 ticks. SDA is then driven low for 5 ticks while SCL stays released. This is exactly one START condition, and the first SCL fall follows it.
- R4: Byte k is taken from `tx_bytes[8k+7:8k]` and bytes go out in the order 0, 1, and so on. Bits go out MSB first, one per SCL slot. SDA changes only while SCL is low, so no extra START or STOP appears inside a transfer.
- R5: In the ninth slot of every byte, SDA is released, and the level read there is ignored.
- R6: After the last acknowledge slot, SDA is held low while SCL rises and is released 2 ticks later. This gives one STOP condition. `done` pulses for one cycle exactly (2 + 9·byte_cnt)·10 ticks after the accepting edge, and `busy` is 0 from that cycle.
- R7: In a data slot where SDA is released, reading SDA low at the sampling point sets `arb_lost` at that edge. At the same edge the engine releases SCL and SDA, clears `busy`, and never pulses `done`. A loss in address bit slot j (0-based, counted from the first bit after START) is flagged (j+1)·10+8 ticks after acceptance.
- R8: `arb_lost` stays 1 through ignored requests and bus idling. It clears only on the edge that accepts a new request.
- R9: `bus_idle` is 1 after reset. It drops the cycle after SDA is seen falling while SCL is high on both samples, from any master. It rises again the cycle after SDA is seen rising while SCL is high.
- R10: During reset and right after it, `scl_oe`, `sda_oe`, `busy`, `done` and `arb_lost` are all 0 and `bus_idle` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tpr | input | TPR_W | Timer period value, latched on acceptance |
| start_req | input | 1 | Request to begin a transfer |
| tx_bytes | input | 8·MAX_BYTES | Message bytes, byte k at bits 8k+7..8k |
| byte_cnt | input | clog2(MAX_BYTES+1) | Number of bytes to send |
| scl_oe | output | 1 | Drive SCL low when 1 |
| scl_in | input | 1 | Resolved SCL level |
| sda_oe | output | 1 | Drive SDA low when 1 |
| sda_in | input | 1 | Resolved SDA level |
| busy | output | 1 | A transfer owned by this engine is in progress |
| done | output | 1 | One-cycle pulse after the STOP condition |
| arb_lost | output | 1 | Arbitration was lost; sticky |
| bus_idle | output | 1 | No START has been seen since the last STOP |

## Verification
Some properties are checked by assertions on every cycle:
- a transfer begins only from an idle bus, with both lines released;
- `done` comes with both lines free and lasts one cycle;
- a loss releases both lines at once and never coincides with `done`;
- the loss flag holds until a request;
- the monitor follows START and STOP edges on the resolved lines.

The bench scenarios cover what needs whole transfers. They measure SCL low, high and period lengths for several timer values, and they decode the bytes, acknowledge bits, START and STOP from the wire. They also check the exact cycle of `done`, and the exact cycle of an arbitration loss in both the address byte and the data byte against a modelled competing master.

// File: rtl/i2cbe_pkg.sv
`timescale 1ns/1ps
package i2cbe_pkg;

   // Engine sequencing states
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_START = 3'd1,
      ST_BIT   = 3'd2,
      ST_ACK   = 3'd3,
      ST_STOP  = 3'd4
   } seq_st_t;

   // Slot geometry in prescaled ticks (behavioural constants)
   localparam int SLOT_TICKS  = 10;  // ticks per SCL slot
   localparam int LOW_TICKS   = 6;   // SCL held low for phases 0..5
   localparam int START_PH    = 5;   // START pulls SDA low from this phase
   localparam int SAMPLE_PH   = 7;   // sample at the end of this phase
   localparam int STOP_REL_PH = 8;   // STOP releases SDA from this phase
   localparam int PH_W        = $clog2(SLOT_TICKS);

endpackage

// File: rtl/i2cbe_tick_gen.sv
`timescale 1ns/1ps
// Prescaler plus slot phase counter. A tick lasts 2*(1+tpr) clocks.
module i2cbe_tick_gen
   import i2cbe_pkg::*;
#(
   parameter int TPR_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic [TPR_W-1:0]   tpr,
   output logic               tick,
   output logic [PH_W-1:0]    ph,
   output logic               slot_end
);
   localparam int CW = TPR_W + 1;

   logic [CW-1:0] div_q;
   logic [CW-1:0] div_lim;

   // 2*tpr + 1 is the last count of a tick
   assign div_lim = {tpr, 1'b1};
   assign tick    = run && (div_q == div_lim);
   assign slot_end = tick && (ph == PH_W'(SLOT_TICKS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
      end else if (!run || tick) begin
         div_q <= '0;
      end else begin
         div_q <= div_q + CW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph <= '0;
      end else if (!run) begin
         ph <= '0;
      end else if (tick) begin
         if (ph == PH_W'(SLOT_TICKS - 1)) begin
            ph <= '0;
         end else begin
            ph <= ph + PH_W'(1);
         end
      end
   end

endmodule

// File: rtl/i2cbe_bus_mon.sv
`timescale 1ns/1ps
// Passive START/STOP watcher on the resolved lines.
module i2cbe_bus_mon #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic bus_idle
);
   logic scl_s, sda_s;
   logic scl_d, sda_d;
   logic idle_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign scl_s = scl_in;
         assign sda_s = sda_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] scl_p, sda_p;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_p <= '1;
               sda_p <= '1;
            end else begin
               scl_p <= SYNC_STAGES'({scl_p, scl_in});
               sda_p <= SYNC_STAGES'({sda_p, sda_in});
            end
         end
         assign scl_s = scl_p[SYNC_STAGES-1];
         assign sda_s = sda_p[SYNC_STAGES-1];
      end
   endgenerate

   logic scl_hi_both;
   assign scl_hi_both = scl_d && scl_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
         idle_q <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
         if (scl_hi_both && sda_d && !sda_s) begin
            idle_q <= 1'b0;
         end else if (scl_hi_both && !sda_d && sda_s) begin
            idle_q <= 1'b1;
         end
      end
   end

   assign bus_idle = idle_q;

endmodule

// File: rtl/i2cbe_seq.sv
`timescale 1ns/1ps
// Transfer sequencer: acceptance, bit/byte stepping, arbitration judge.
module i2cbe_seq
   import i2cbe_pkg::*;
#(
   parameter int TPR_W     = 8,
   parameter int MAX_BYTES = 2,
   parameter int CNT_W     = $clog2(MAX_BYTES + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start_req,
   input  logic [TPR_W-1:0]       tpr,
   input  logic [8*MAX_BYTES-1:0] tx_bytes,
   input  logic [CNT_W-1:0]       byte_cnt,
   input  logic                   bus_idle,
   input  logic                   sda_in,
   input  logic                   tick,
   input  logic [PH_W-1:0]        ph,
   input  logic                   slot_end,
   output seq_st_t                state,
   output logic                   cur_bit,
   output logic [TPR_W-1:0]       tpr_q,
   output logic                   busy,
   output logic                   done,
   output logic                   arb_lost
);
   localparam int IDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

   logic [8*MAX_BYTES-1:0] data_q;
   logic [CNT_W-1:0]       cnt_q;
   logic [IDX_W-1:0]       byte_idx;
   logic [2:0]             bit_idx;
   logic [7:0]             byte_arr [MAX_BYTES];

   generate
      for (genvar g = 0; g < MAX_BYTES; g++) begin : g_unpack
         assign byte_arr[g] = data_q[8*g +: 8];
      end
   endgenerate

   logic cnt_ok, accept, last_byte, sample_pt, arb_hit;

   assign cnt_ok    = (byte_cnt != '0) && (byte_cnt <= CNT_W'(MAX_BYTES));
   assign accept    = (state == ST_IDLE) && start_req && bus_idle && cnt_ok;
   assign cur_bit   = byte_arr[byte_idx][bit_idx];
   assign last_byte = (CNT_W'(byte_idx) == (cnt_q - CNT_W'(1)));
   assign sample_pt = tick && (ph == PH_W'(SAMPLE_PH));
   // released '1' read back as '0' while SCL is high
   assign arb_hit   = (state == ST_BIT) && sample_pt && cur_bit && !sda_in;
   assign busy      = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         data_q   <= '0;
         cnt_q    <= '0;
         tpr_q    <= '0;
         byte_idx <= '0;
         bit_idx  <= '0;
         done     <= 1'b0;
         arb_lost <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  state    <= ST_START;
                  data_q   <= tx_bytes;
                  cnt_q    <= byte_cnt;
                  tpr_q    <= tpr;
                  byte_idx <= '0;
                  bit_idx  <= 3'd7;
                  arb_lost <= 1'b0;
               end
            end
            ST_START: begin
               if (slot_end) begin
                  state <= ST_BIT;
               end
            end
            ST_BIT: begin
               if (arb_hit) begin
                  state    <= ST_IDLE;
                  arb_lost <= 1'b1;
               end else if (slot_end) begin
                  if (bit_idx == 3'd0) begin
                     state <= ST_ACK;
                  end else begin
                     bit_idx <= bit_idx - 3'd1;
                  end
               end
            end
            ST_ACK: begin
               if (slot_end) begin
                  if (last_byte) begin
                     state <= ST_STOP;
                  end else begin
                     state    <= ST_BIT;
                     byte_idx <= byte_idx + IDX_W'(1);
                     bit_idx  <= 3'd7;
                  end
               end
            end
            ST_STOP: begin
               if (slot_end) begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/i2cbe_line_drv.sv
`timescale 1ns/1ps
// Decodes line enables from sequencer state and slot phase.
module i2cbe_line_drv
   import i2cbe_pkg::*;
(
   input  seq_st_t          state,
   input  logic [PH_W-1:0]  ph,
   input  logic             cur_bit,
   output logic             scl_oe,
   output logic             sda_oe
);
   logic scl_low_ph;
   assign scl_low_ph = (ph < PH_W'(LOW_TICKS));

   always_comb begin
      scl_oe = 1'b0;
      sda_oe = 1'b0;
      unique case (state)
         ST_IDLE: begin
            scl_oe = 1'b0;
            sda_oe = 1'b0;
         end
         ST_START: begin
            scl_oe = 1'b0;
            sda_oe = (ph >= PH_W'(START_PH));
         end
         ST_BIT: begin
            scl_oe = scl_low_ph;
            sda_oe = !cur_bit;
         end
         ST_ACK: begin
            scl_oe = scl_low_ph;
            sda_oe = 1'b0;
         end
         ST_STOP: begin
            scl_oe = scl_low_ph;
            sda_oe = (ph < PH_W'(STOP_REL_PH));
         end
         default: begin
            scl_oe = 1'b0;
            sda_oe = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/i2cbe_top.sv
`timescale 1ns/1ps
module i2cbe_top
   import i2cbe_pkg::*;
#(
   parameter int TPR_W       = 8,
   parameter int MAX_BYTES   = 2,
   parameter int SYNC_STAGES = 0,
   parameter int CNT_W       = $clog2(MAX_BYTES + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [TPR_W-1:0]       tpr,
   input  logic                   start_req,
   input  logic [8*MAX_BYTES-1:0] tx_bytes,
   input  logic [CNT_W-1:0]       byte_cnt,
   output logic                   scl_oe,
   input  logic                   scl_in,
   output logic                   sda_oe,
   input  logic                   sda_in,
   output logic                   busy,
   output logic                   done,
   output logic                   arb_lost,
   output logic                   bus_idle
);
   // Elaboration-time parameter checks
   generate
      if (TPR_W < 1 || TPR_W > 16) begin : g_bad_tpr_w
         $error("i2cbe_top: TPR_W must be in 1..16");
      end
      if (MAX_BYTES < 1 || MAX_BYTES > 64) begin : g_bad_max_bytes
         $error("i2cbe_top: MAX_BYTES must be in 1..64");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("i2cbe_top: SYNC_STAGES must be in 0..3");
      end
      if (CNT_W < $clog2(MAX_BYTES + 1)) begin : g_bad_cnt_w
         $error("i2cbe_top: CNT_W too narrow for MAX_BYTES");
      end
   endgenerate

   seq_st_t           state;
   logic              cur_bit;
   logic [TPR_W-1:0]  tpr_q;
   logic              tick;
   logic [PH_W-1:0]   ph;
   logic              slot_end;
   logic              run;

   assign run = (state != ST_IDLE);

   i2cbe_tick_gen #(.TPR_W(TPR_W)) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .tpr      (tpr_q),
      .tick     (tick),
      .ph       (ph),
      .slot_end (slot_end)
   );

   i2cbe_bus_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_in   (scl_in),
      .sda_in   (sda_in),
      .bus_idle (bus_idle)
   );

   i2cbe_seq #(
      .TPR_W     (TPR_W),
      .MAX_BYTES (MAX_BYTES),
      .CNT_W     (CNT_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_req (start_req),
      .tpr       (tpr),
      .tx_bytes  (tx_bytes),
      .byte_cnt  (byte_cnt),
      .bus_idle  (bus_idle),
      .sda_in    (sda_in),
      .tick      (tick),
      .ph        (ph),
      .slot_end  (slot_end),
      .state     (state),
      .cur_bit   (cur_bit),
      .tpr_q     (tpr_q),
      .busy      (busy),
      .done      (done),
      .arb_lost  (arb_lost)
   );

   i2cbe_line_drv u_drv (
      .state   (state),
      .ph      (ph),
      .cur_bit (cur_bit),
      .scl_oe  (scl_oe),
      .sda_oe  (sda_oe)
   );

endmodule

// File: rtl/i2cbe_chk.sv
`timescale 1ns/1ps
module i2cbe_chk #(
   parameter int SYNC_STAGES = 0
) (
   input logic clk,
   input logic rst_n,
   input logic start_req,
   input logic scl_oe,
   input logic sda_oe,
   input logic scl_in,
   input logic sda_in,
   input logic busy,
   input logic done,
   input logic arb_lost,
   input logic bus_idle
);
   // R2
   start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start_req) && $past(bus_idle));

   // R3
   start_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !scl_oe && !sda_oe);

   // R6
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && !scl_oe && !sda_oe);

   // R6
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7
   arb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arb_lost) |-> !busy && !scl_oe && !sda_oe && !done);

   // R8
   arb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arb_lost && !start_req |=> arb_lost);

   // R8
   arb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(arb_lost) |-> $past(start_req) && busy);

   generate
      if (SYNC_STAGES == 0) begin : g_mon_chk
         // R9
         idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            scl_in && $past(scl_in) && $fell(sda_in) |=> !bus_idle);

         // R9
         idle_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            scl_in && $past(scl_in) && $rose(sda_in) |=> bus_idle);
      end
   endgenerate

endmodule

bind i2cbe_top i2cbe_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_req (start_req),
   .scl_oe    (scl_oe),
   .sda_oe    (sda_oe),
   .scl_in    (scl_in),
   .sda_in    (sda_in),
   .busy      (busy),
   .done      (done),
   .arb_lost  (arb_lost),
   .bus_idle  (bus_idle)
);

// File: tb/tb_i2cbe_top.sv
`timescale 1ns/1ps
module tb_i2cbe_top;
   localparam int TPR_W     = 8;
   localparam int MAX_BYTES = 2;
   localparam int CNT_W     = $clog2(MAX_BYTES + 1);
   localparam int CLK_NS    = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [TPR_W-1:0]       tpr = '0;
   logic                   start_req = 1'b0;
   logic [8*MAX_BYTES-1:0] tx_bytes = '0;
   logic [CNT_W-1:0]       byte_cnt = '0;
   logic scl_oe, sda_oe, scl_in, sda_in, busy, done, arb_lost, bus_idle;

   // Other bus agents
   logic other_scl = 1'b0;
   logic man_sda   = 1'b0;
   logic model_sda = 1'b0;

   assign scl_in = ~(scl_oe | other_scl);
   assign sda_in = ~(sda_oe | man_sda | model_sda);

   i2cbe_top #(.TPR_W(TPR_W), .MAX_BYTES(MAX_BYTES)) dut (
      .clk(clk), .rst_n(rst_n), .tpr(tpr), .start_req(start_req),
      .tx_bytes(tx_bytes), .byte_cnt(byte_cnt),
      .scl_oe(scl_oe), .scl_in(scl_in), .sda_oe(sda_oe), .sda_in(sda_in),
      .busy(busy), .done(done), .arb_lost(arb_lost), .bus_idle(bus_idle)
   );

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s : actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Wire observer: bits on SCL rise, timing of the first slots
   logic     obs_en = 1'b0;
   int       obs_n = 0;
   logic [31:0] obs_bits = '0;
   realtime  last_rise = 0.0;
   realtime  per = 0.0;
   realtime  hi_len = 0.0;

   always @(posedge scl_in or negedge obs_en) begin
      if (!obs_en) begin
         obs_n = 0;
         obs_bits = '0;
      end else begin
         obs_bits = {obs_bits[30:0], sda_in};
         if (obs_n == 1) per = $realtime - last_rise;
         last_rise = $realtime;
         obs_n = obs_n + 1;
      end
   end

   always @(negedge scl_in) begin
      if (obs_en && obs_n == 1) hi_len = $realtime - last_rise;
   end

   int  n_starts = 0;
   int  n_stops  = 0;
   logic p_scl = 1'b1;
   logic p_sda = 1'b1;
   always @(negedge clk) begin
      if (obs_en) begin
         if (p_scl && scl_in && p_sda && !sda_in) n_starts = n_starts + 1;
         if (p_scl && scl_in && !p_sda && sda_in) n_stops = n_stops + 1;
      end else begin
         n_starts = 0;
         n_stops = 0;
      end
      p_scl = scl_in;
      p_sda = sda_in;
   end

   // Competing master: follows SCL falls, drives its own bits
   logic arb_en = 1'b0;
   int   slot = -1;
   logic [15:0] oth = '0;
   int   oth_cnt = 0;
   always @(negedge scl_in or negedge arb_en) begin
      if (!arb_en) begin
         slot = -1;
         model_sda = 1'b0;
      end else begin
         slot = slot + 1;
         if ((slot / 9) < oth_cnt && (slot % 9) < 8)
            model_sda = ~oth[8 * (slot / 9) + 7 - (slot % 9)];
         else
            model_sda = 1'b0;
      end
   end

   task automatic do_xfer(input int tp, input int cnt, input logic [15:0] data, input bit rival);
      int n;
      int tk;
      int nb;
      longint e;
      tk = 2 * (tp + 1);
      @(negedge clk);
      tpr = TPR_W'(tp);
      tx_bytes = data;
      byte_cnt = CNT_W'(cnt);
      obs_en = 1'b1;
      if (rival) begin
         oth = data;
         oth_cnt = cnt;
         arb_en = 1'b1;
      end
      start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
      chk("R2 busy after accepted request", busy, 1);
      n = 0;
      while (!done && n < 50000) begin
         @(negedge clk);
         n++;
      end
      chk("R6 cycle of done pulse", n, (2 + 9 * cnt) * 10 * tk);
      chk("R6 busy low with done", busy, 0);
      nb = 9 * cnt + 1;
      chk("R4 SCL rising edges in transfer", obs_n, nb);
      e = 0;
      for (int k = 0; k < cnt; k++) begin
         e = (e << 8) | longint'(data[8*k +: 8]);
         e = (e << 1) | 1;   // acknowledge slot released
      end
      e = e << 1;            // STOP slot rise with SDA low
      chk("R4 R5 decoded wire bits", longint'(obs_bits) & ((64'd1 << nb) - 1), e);
      for (int k = 0; k < cnt; k++)
         chk("R5 ack slot released", obs_bits[nb - 1 - (9 * k + 8)], 1);
      chk("R1 SCL period clocks", $rtoi(per) / CLK_NS, 10 * tk);
      chk("R1 SCL high clocks", $rtoi(hi_len) / CLK_NS, 4 * tk);
      chk("R3 single START seen", n_starts, 1);
      chk("R6 single STOP seen", n_stops, 1);
      @(negedge clk);
      chk("R6 done lasts one cycle", done, 0);
      chk("R9 bus idle after own STOP", bus_idle, 1);
      if (rival) chk("R7 no loss with identical rival", arb_lost, 0);
      obs_en = 1'b0;
      arb_en = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic do_arb(input int tp, input logic [15:0] ours, input logic [15:0] theirs, input int exp_ticks);
      int n;
      bit seen_done;
      int tk;
      tk = 2 * (tp + 1);
      @(negedge clk);
      tpr = TPR_W'(tp);
      tx_bytes = ours;
      byte_cnt = CNT_W'(2);
      oth = theirs;
      oth_cnt = 2;
      arb_en = 1'b1;
      start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
      chk("R8 arb_lost cleared on accepted request", arb_lost, 0);
      n = 0;
      seen_done = 1'b0;
      while (!arb_lost && n < 50000) begin
         @(negedge clk);
         n++;
         if (done) seen_done = 1'b1;
      end
      chk("R7 cycle of arbitration loss", n, exp_ticks * tk);
      chk("R7 SCL released on loss", scl_oe, 0);
      chk("R7 SDA released on loss", sda_oe, 0);
      chk("R7 busy low on loss", busy, 0);
      chk("R7 no done on loss", seen_done, 0);
      chk("R9 bus stays busy after loss", bus_idle, 0);
      start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
      repeat (40) @(negedge clk);
      chk("R2 request ignored while bus busy", busy, 0);
      chk("R2 SCL not driven while bus busy", scl_oe, 0);
      chk("R8 arb_lost held across ignored request", arb_lost, 1);
      // rival finishes with a STOP
      man_sda = 1'b1;
      other_scl = 1'b1;
      repeat (4) @(negedge clk);
      arb_en = 1'b0;
      repeat (2) @(negedge clk);
      other_scl = 1'b0;
      repeat (4) @(negedge clk);
      man_sda = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9 bus idle after rival STOP", bus_idle, 1);
      chk("R8 arb_lost held after bus idle", arb_lost, 1);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog : actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset values while held
      chk("R10 scl_oe in reset", scl_oe, 0);
      chk("R10 sda_oe in reset", sda_oe, 0);
      chk("R10 busy in reset", busy, 0);
      chk("R10 done in reset", done, 0);
      chk("R10 arb_lost in reset", arb_lost, 0);
      chk("R10 bus_idle in reset", bus_idle, 1);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R10 busy after reset", busy, 0);
      chk("R9 bus idle after reset", bus_idle, 1);

      // Sweep timer value, byte count and data patterns
      for (int tp = 0; tp < 4; tp++) begin
         for (int c = 1; c <= MAX_BYTES; c++) begin
            do_xfer(tp, c, 16'h3CA5, 1'b0);
            do_xfer(tp, c, 16'h00FF, 1'b0);
            do_xfer(tp, c, 16'h8001, 1'b0);
         end
      end

      // R2 out-of-range byte counts are ignored
      @(negedge clk);
      byte_cnt = '0;
      start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
      repeat (20) @(negedge clk);
      chk("R2 byte_cnt 0 ignored (busy)", busy, 0);
      chk("R2 byte_cnt 0 ignored (scl)", scl_oe, 0);
      byte_cnt = CNT_W'(MAX_BYTES + 1);
      start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
      repeat (20) @(negedge clk);
      chk("R2 byte_cnt above max ignored", busy, 0);
      chk("R2 byte_cnt above max leaves SDA", sda_oe, 0);

      // R9 foreign START / STOP while this engine is idle
      man_sda = 1'b1;
      repeat (3) @(negedge clk);
      chk("R9 foreign START clears idle", bus_idle, 0);
      byte_cnt = CNT_W'(1);
      start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
      repeat (30) @(negedge clk);
      chk("R2 request ignored after foreign START", busy, 0);
      chk("R2 no SDA drive after foreign START", sda_oe, 0);
      man_sda = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9 foreign STOP sets idle", bus_idle, 1);

      // R7 loss in address bit slot 2: ours B4, rival 94
      do_arb(1, 16'h55B4, 16'h5594, 38);
      // R7 loss in data byte after equal address: slot 10
      do_arb(0, 16'hC352, 16'h8352, 118);
      // R8 a later accepted transfer clears the flag and runs normally
      do_xfer(2, 2, 16'h6A52, 1'b1);
      chk("R8 flag clear after accepted transfer", arb_lost, 0);

      finish_run();
   end

endmodule